// File: doc/BRIEF.md
# Clock Source Startup Sequencer

This block brings the system clock of a chip up from its internal oscillator to a configured source, in an order that keeps every source stable before anything depends on it. A start pulse captures a configuration: whether the external oscillator is used, whether the PLL is used, the requested PLL factor, and the external oscillator frequency in MHz. From that configuration the block works out the resulting system clock frequency, the PLL multiplier field, the flash wait-state count and the clock mux code. It rejects any configuration that would run the system clock above its ceiling.

An accepted configuration is carried out as a fixed sequence. If the mux currently runs from the PLL, the mux is first parked on the internal oscillator. The external oscillator is then enabled and waited on if it is used. If the PLL is used, it is disabled, its fields are written once its lock has dropped, and it is re-enabled and waited on. Wait states are raised before the mux switch, or lowered after it, and a one-cycle done pulse closes the sequence. Every wait is bounded by a timeout that raises an error flag and returns the block to idle. The oscillator and PLL are outside the block and report back through ready and lock inputs.

Top module: `clk_bringup_seq`

## Requirements
- R1: When the external oscillator is selected, `xosc_en` goes high and the sequence stalls, with no mux change and no done pulse, until `xosc_ready` is high.
- R2: `pll_mul_code` equals the requested factor clamped to 2..16, minus 2 (so 0 to 14).
- R3: `pll_src_ext` is 1 when the external oscillator feeds the PLL and 0 when the PLL runs from the internal oscillator halved (8 MHz / 2 = 4 MHz). The system clock is then the PLL input times the clamped factor. Without the PLL it is the external frequency, or 8 MHz.
- R4: `pll_mul_code` and `pll_src_ext` change only while `pll_en` is low. `pll_en` rises only after they are written and `pll_locked` has been seen low. The sequence waits for `pll_locked` before going on.
- R5: `clk_sel` is 2'b10 for PLL, 2'b01 for external and 2'b00 for internal. It is written only after the chosen source is enabled and ready.
- R6: `flash_ws` is 0 for a system clock up to 24 MHz, 1 for up to 48 MHz, and 2 above 48 MHz.
- R7: When the wait-state count rises it is written before the mux switch. When it falls it is written after the switch.
- R8: A configuration above 72 MHz raises `err_reject` in the cycle after start. The block produces no done pulse and leaves every clock output unchanged.
- R9: A ready or lock wait that lasts `TIMEOUT_CYC` cycles raises `err_timeout` and returns the block to idle. The mux select and wait states are left unchanged.
- R10: `done` is high for exactly one cycle after the final write. Start pulses during a sequence are ignored. Error flags clear on the next accepted start.
- R11: If `clk_sel` is 2'b10 when a sequence starts, it is moved to 2'b00 before the PLL is touched.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; sampled only when idle |
| cfg_use_ext | input | 1 | Use the external oscillator |
| cfg_pll_en | input | 1 | Use the PLL |
| cfg_pll_factor | input | FAC_W | Requested PLL factor (clamped) |
| cfg_ext_mhz | input | EXT_W | External oscillator frequency in MHz |
| xosc_ready | input | 1 | External oscillator ready |
| pll_locked | input | 1 | PLL lock indication |
| xosc_en | output | 1 | External oscillator enable |
| pll_en | output | 1 | PLL enable |
| pll_src_ext | output | 1 | PLL input: 1 external, 0 internal/2 |
| pll_mul_code | output | 4 | PLL factor minus 2 |
| clk_sel | output | 2 | System clock mux code |
| flash_ws | output | 2 | Flash wait-state count |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | A ready/lock wait timed out |
| err_reject | output | 1 | Configuration exceeded the frequency ceiling |

## Verification
The bench builds the block with `TIMEOUT_CYC` at 64 and leaves the frequency limits at their defaults (8, 24, 48 and 72 MHz). It drives oscillator and PLL models that respond 3 and 5 cycles after their enables and can be made to never respond. The short timeout puts both the oscillator timeout and the PLL timeout within a few hundred cycles. The default limits let the bench hit the 24/25, 48/49 and 72/73 MHz edges exactly with a directly used external oscillator.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;

  localparam logic [1:0] SEL_INT = 2'b00;
  localparam logic [1:0] SEL_EXT = 2'b01;
  localparam logic [1:0] SEL_PLL = 2'b10;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PREP,
    S_XOSC_WAIT,
    S_PLL_CFG,
    S_PLL_WAIT,
    S_WS_UP,
    S_SWITCH,
    S_WS_DOWN
  } seq_state_t;

  // Decoded outcome of one configuration.
  typedef struct packed {
    logic       reject;
    logic       use_ext;
    logic       use_pll;
    logic [1:0] sel;
    logic [1:0] ws;
    logic [3:0] mul_code;
  } seq_plan_t;

endpackage

// File: rtl/clk_seq_plan.sv
module clk_seq_plan
  import clk_seq_pkg::*;
#(
  parameter int INT_MHZ = 8,
  parameter int MAX_MHZ = 72,
  parameter int WS1_MHZ = 24,
  parameter int WS2_MHZ = 48,
  parameter int MUL_MIN = 2,
  parameter int MUL_MAX = 16,
  parameter int FAC_W   = 5,
  parameter int EXT_W   = 7
) (
  input  logic             use_ext,
  input  logic             use_pll,
  input  logic [FAC_W-1:0] factor,
  input  logic [EXT_W-1:0] ext_mhz,
  output seq_plan_t        plan
);

  localparam int FREQ_W = EXT_W + FAC_W;

  logic [FAC_W-1:0]  fac_c;
  logic [FREQ_W-1:0] pll_in_mhz;
  logic [FREQ_W-1:0] sys_mhz;

  // Clamp requested factor into the supported range.
  always_comb begin
    fac_c = factor;
    if (factor < FAC_W'(MUL_MIN)) begin
      fac_c = FAC_W'(MUL_MIN);
    end else if (factor > FAC_W'(MUL_MAX)) begin
      fac_c = FAC_W'(MUL_MAX);
    end
  end

  always_comb begin
    pll_in_mhz = use_ext ? FREQ_W'(ext_mhz) : FREQ_W'(INT_MHZ / 2);
    if (use_pll) begin
      sys_mhz = pll_in_mhz * FREQ_W'(fac_c);
    end else if (use_ext) begin
      sys_mhz = FREQ_W'(ext_mhz);
    end else begin
      sys_mhz = FREQ_W'(INT_MHZ);
    end
  end

  always_comb begin
    plan.reject   = (sys_mhz > FREQ_W'(MAX_MHZ));
    plan.use_ext  = use_ext;
    plan.use_pll  = use_pll;
    plan.mul_code = 4'(fac_c - FAC_W'(MUL_MIN));
    if (sys_mhz <= FREQ_W'(WS1_MHZ)) begin
      plan.ws = 2'd0;
    end else if (sys_mhz <= FREQ_W'(WS2_MHZ)) begin
      plan.ws = 2'd1;
    end else begin
      plan.ws = 2'd2;
    end
    if (use_pll) begin
      plan.sel = SEL_PLL;
    end else if (use_ext) begin
      plan.sel = SEL_EXT;
    end else begin
      plan.sel = SEL_INT;
    end
  end

  always_comb begin
    a_code_range_r2: assert (plan.mul_code <= 4'(MUL_MAX - MUL_MIN));
  end

endmodule

// File: rtl/clk_seq_timeout.sv
module clk_seq_timeout #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (!run || clr) begin
      cnt_n = '0;
    end else if (cnt_q != LAST) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign expired = run && (cnt_q == LAST);

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  p_cnt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> cnt_q == '0);

endmodule

// File: rtl/clk_bringup_seq.sv
module clk_bringup_seq
  import clk_seq_pkg::*;
#(
  parameter int INT_MHZ     = 8,
  parameter int MAX_MHZ     = 72,
  parameter int WS1_MHZ     = 24,
  parameter int WS2_MHZ     = 48,
  parameter int TIMEOUT_CYC = 4096,
  parameter int FAC_W       = 5,
  parameter int EXT_W       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_use_ext,
  input  logic             cfg_pll_en,
  input  logic [FAC_W-1:0] cfg_pll_factor,
  input  logic [EXT_W-1:0] cfg_ext_mhz,
  input  logic             xosc_ready,
  input  logic             pll_locked,
  output logic             xosc_en,
  output logic             pll_en,
  output logic             pll_src_ext,
  output logic [3:0]       pll_mul_code,
  output logic [1:0]       clk_sel,
  output logic [1:0]       flash_ws,
  output logic             done,
  output logic             err_timeout,
  output logic             err_reject
);

  seq_state_t state_q, state_n;
  seq_plan_t  plan_c, lat_q, lat_n;

  logic       xosc_en_q, xosc_en_n;
  logic       pll_en_q, pll_en_n;
  logic       src_q, src_n;
  logic [3:0] mul_q, mul_n;
  logic [1:0] sel_q, sel_n;
  logic [1:0] ws_q, ws_n;
  logic       done_q, done_n;
  logic       terr_q, terr_n;
  logic       rerr_q, rerr_n;

  logic       wait_run, wait_clr, wait_expired;
  logic       load_pll, go_order;

  clk_seq_plan #(
    .INT_MHZ (INT_MHZ),
    .MAX_MHZ (MAX_MHZ),
    .WS1_MHZ (WS1_MHZ),
    .WS2_MHZ (WS2_MHZ),
    .MUL_MIN (2),
    .MUL_MAX (16),
    .FAC_W   (FAC_W),
    .EXT_W   (EXT_W)
  ) u_plan (
    .use_ext (cfg_use_ext),
    .use_pll (cfg_pll_en),
    .factor  (cfg_pll_factor),
    .ext_mhz (cfg_ext_mhz),
    .plan    (plan_c)
  );

  assign wait_run = (state_q == S_XOSC_WAIT) || (state_q == S_PLL_CFG) ||
                    (state_q == S_PLL_WAIT);
  assign wait_clr = (state_n != state_q);

  clk_seq_timeout #(
    .LIMIT (TIMEOUT_CYC)
  ) u_timeout (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (wait_run),
    .clr     (wait_clr),
    .expired (wait_expired)
  );

  // Next-state and output-update logic.
  always_comb begin
    state_n   = state_q;
    lat_n     = lat_q;
    xosc_en_n = xosc_en_q;
    pll_en_n  = pll_en_q;
    src_n     = src_q;
    mul_n     = mul_q;
    sel_n     = sel_q;
    ws_n      = ws_q;
    done_n    = 1'b0;
    terr_n    = terr_q;
    rerr_n    = rerr_q;
    load_pll  = 1'b0;
    go_order  = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          terr_n = 1'b0;
          rerr_n = plan_c.reject;
          if (!plan_c.reject) begin
            lat_n   = plan_c;
            state_n = S_PREP;
          end
        end
      end
      S_PREP: begin
        if (sel_q == SEL_PLL) begin
          sel_n = SEL_INT;              // park; re-evaluate next cycle
        end else if (lat_q.use_ext) begin
          xosc_en_n = 1'b1;
          state_n   = S_XOSC_WAIT;
        end else if (lat_q.use_pll) begin
          load_pll = 1'b1;
        end else begin
          go_order = 1'b1;
        end
      end
      S_XOSC_WAIT: begin
        if (xosc_ready) begin
          if (lat_q.use_pll) begin
            load_pll = 1'b1;
          end else begin
            go_order = 1'b1;
          end
        end else if (wait_expired) begin
          terr_n  = 1'b1;
          state_n = S_IDLE;
        end
      end
      S_PLL_CFG: begin
        if (!pll_locked) begin
          pll_en_n = 1'b1;
          state_n  = S_PLL_WAIT;
        end else if (wait_expired) begin
          terr_n  = 1'b1;
          state_n = S_IDLE;
        end
      end
      S_PLL_WAIT: begin
        if (pll_locked) begin
          go_order = 1'b1;
        end else if (wait_expired) begin
          terr_n  = 1'b1;
          state_n = S_IDLE;
        end
      end
      S_WS_UP: begin
        ws_n    = lat_q.ws;
        state_n = S_SWITCH;
      end
      S_SWITCH: begin
        sel_n = lat_q.sel;
        if (lat_q.ws < ws_q) begin
          state_n = S_WS_DOWN;
        end else begin
          done_n  = 1'b1;
          state_n = S_IDLE;
        end
      end
      S_WS_DOWN: begin
        ws_n    = lat_q.ws;
        done_n  = 1'b1;
        state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase

    if (load_pll) begin
      pll_en_n = 1'b0;
      mul_n    = lat_q.mul_code;
      src_n    = lat_q.use_ext;
      state_n  = S_PLL_CFG;
    end
    if (go_order) begin
      state_n = (lat_q.ws > ws_q) ? S_WS_UP : S_SWITCH;
    end
  end

  // State and output registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      lat_q     <= '0;
      xosc_en_q <= 1'b0;
      pll_en_q  <= 1'b0;
      src_q     <= 1'b0;
      mul_q     <= '0;
      sel_q     <= SEL_INT;
      ws_q      <= '0;
      done_q    <= 1'b0;
      terr_q    <= 1'b0;
      rerr_q    <= 1'b0;
    end else begin
      state_q   <= state_n;
      lat_q     <= lat_n;
      xosc_en_q <= xosc_en_n;
      pll_en_q  <= pll_en_n;
      src_q     <= src_n;
      mul_q     <= mul_n;
      sel_q     <= sel_n;
      ws_q      <= ws_n;
      done_q    <= done_n;
      terr_q    <= terr_n;
      rerr_q    <= rerr_n;
    end
  end

  assign xosc_en      = xosc_en_q;
  assign pll_en       = pll_en_q;
  assign pll_src_ext  = src_q;
  assign pll_mul_code = mul_q;
  assign clk_sel      = sel_q;
  assign flash_ws     = ws_q;
  assign done         = done_q;
  assign err_timeout  = terr_q;
  assign err_reject   = rerr_q;

  p_fields_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_en_q && $past(pll_en_q)) |-> ($stable(mul_q) && $stable(src_q)));

  p_enable_after_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en_q) |-> !$past(pll_locked));

  p_pll_sel_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == SEL_PLL && $past(sel_q) != SEL_PLL) |-> pll_en_q);

  p_ext_sel_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == SEL_EXT && $past(sel_q) != SEL_EXT) |-> xosc_en_q);

  p_ws_covers_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state_q == S_SWITCH) |-> $past(ws_q) >= lat_q.ws);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_park_before_pll_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en_q) |-> sel_q != SEL_PLL);

  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mul_q <= 4'd14);

endmodule

// File: tb/clk_bringup_seq_test.sv
`timescale 1ns/1ps
module clk_bringup_seq_test;

  localparam int TMO  = 64;
  localparam int XDLY = 3;
  localparam int PDLY = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       cfg_use_ext = 1'b0;
  logic       cfg_pll_en = 1'b0;
  logic [4:0] cfg_pll_factor = '0;
  logic [6:0] cfg_ext_mhz = '0;
  logic       xosc_ready, pll_locked;
  logic       xosc_en, pll_en, pll_src_ext, done, err_timeout, err_reject;
  logic [3:0] pll_mul_code;
  logic [1:0] clk_sel, flash_ws;

  logic       xosc_dead = 1'b0;
  logic       pll_dead = 1'b0;
  logic [XDLY-1:0] xo_sh;
  logic [PDLY-1:0] pl_sh;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  clk_bringup_seq #(.TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_use_ext(cfg_use_ext), .cfg_pll_en(cfg_pll_en),
    .cfg_pll_factor(cfg_pll_factor), .cfg_ext_mhz(cfg_ext_mhz),
    .xosc_ready(xosc_ready), .pll_locked(pll_locked),
    .xosc_en(xosc_en), .pll_en(pll_en), .pll_src_ext(pll_src_ext),
    .pll_mul_code(pll_mul_code), .clk_sel(clk_sel), .flash_ws(flash_ws),
    .done(done), .err_timeout(err_timeout), .err_reject(err_reject)
  );

  // Oscillator and PLL response models.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xo_sh <= '0;
      pl_sh <= '0;
    end else begin
      xo_sh <= {xo_sh[XDLY-2:0], xosc_en & ~xosc_dead};
      pl_sh <= {pl_sh[PDLY-2:0], pll_en & ~pll_dead};
    end
  end
  assign xosc_ready = xo_sh[XDLY-1];
  assign pll_locked = pl_sh[PDLY-1];

  // Port monitors.
  logic [1:0] prev_sel;
  logic [3:0] prev_mul;
  logic       prev_src, prev_pen;
  int field_viol = 0;
  int sel_changes = 0;
  int last_switch_ws = -1;
  bit saw_int = 0;
  bit saw_pll_off = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pll_en && prev_pen && (pll_mul_code != prev_mul || pll_src_ext != prev_src))
        field_viol++;
      if (clk_sel != prev_sel) begin
        sel_changes++;
        last_switch_ws = int'(flash_ws);
      end
      if (clk_sel == 2'b00) saw_int = 1;
      if (!pll_en) saw_pll_off = 1;
    end
    prev_sel = clk_sel;
    prev_mul = pll_mul_code;
    prev_src = pll_src_ext;
    prev_pen = pll_en;
  end

  // Watchdog.
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_mhz(bit ue, bit up, int fac, int ext);
    int f;
    f = (fac < 2) ? 2 : ((fac > 16) ? 16 : fac);
    if (up) return (ue ? ext : 4) * f;
    return ue ? ext : 8;
  endfunction

  function automatic int exp_ws(int mhz);
    if (mhz <= 24) return 0;
    if (mhz <= 48) return 1;
    return 2;
  endfunction

  function automatic int exp_code(int fac);
    int f;
    f = (fac < 2) ? 2 : ((fac > 16) ? 16 : fac);
    return f - 2;
  endfunction

  // Results of the last run.
  bit r_done, r_terr, r_rerr;
  int r_width, r_cyc;

  task automatic launch(input bit ue, input bit up, input int fac, input int ext);
    @(negedge clk);
    #1;
    saw_int = 0;
    saw_pll_off = 0;
    sel_changes = 0;
    last_switch_ws = -1;
    cfg_use_ext = ue;
    cfg_pll_en = up;
    cfg_pll_factor = 5'(fac);
    cfg_ext_mhz = 7'(ext);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    r_done = 0; r_terr = 0; r_rerr = 0; r_width = 0; r_cyc = 0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin
        r_done = 1;
        r_width++;
      end
      if (err_timeout) r_terr = 1;
      if (err_reject) r_rerr = 1;
      if ((r_done && !done) || r_terr || r_rerr) break;
      r_cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_ok(input string req, input bit ue, input bit up,
                        input int fac, input int ext);
    int mhz;
    mhz = exp_mhz(ue, up, fac, ext);
    launch(ue, up, fac, ext);
    wait_end();
    chk(r_done && !r_terr && !r_rerr, req, "sequence completes", int'(r_done), 1);
    chk(r_width == 1, "R10", "done width", r_width, 1);
    chk(int'(flash_ws) == exp_ws(mhz), "R6", "wait states", int'(flash_ws), exp_ws(mhz));
    chk(int'(clk_sel) == (up ? 2 : (ue ? 1 : 0)), "R5", "mux code",
        int'(clk_sel), up ? 2 : (ue ? 1 : 0));
  endtask

  task automatic t_reset();
    chk(!xosc_en && !pll_en && !pll_src_ext && pll_mul_code == 0 && clk_sel == 0 &&
        flash_ws == 0 && !done && !err_timeout && !err_reject, "R12", "reset outputs",
        int'({xosc_en, pll_en, pll_src_ext, pll_mul_code, clk_sel, flash_ws, done,
              err_timeout, err_reject}), 0);
  endtask

  task automatic t_internal();
    run_ok("R5", 0, 0, 0, 0);
    chk(!xosc_en && !pll_en, "R5", "no source enabled", int'({xosc_en, pll_en}), 0);
  endtask

  task automatic t_ext_direct();
    run_ok("R1", 1, 0, 0, 8);
    chk(xosc_en, "R1", "xosc enabled", int'(xosc_en), 1);
    chk(r_cyc > XDLY, "R1", "waited for ready", r_cyc, XDLY + 1);
  endtask

  task automatic t_pll_internal_busy_start();
    launch(0, 1, 9, 0);
    // A second start with another configuration is ignored (R10).
    @(negedge clk);
    cfg_use_ext = 1'b1; cfg_pll_en = 1'b0; cfg_ext_mhz = 7'd20;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end();
    chk(r_done && r_width == 1, "R10", "busy start ignored, done once", r_width, 1);
    chk(clk_sel == 2'b10, "R10", "first config kept", int'(clk_sel), 2);
    chk(int'(pll_mul_code) == exp_code(9), "R2", "code for x9", int'(pll_mul_code), 7);
    chk(!pll_src_ext, "R3", "internal half feeds PLL", int'(pll_src_ext), 0);
    chk(int'(flash_ws) == exp_ws(exp_mhz(0, 1, 9, 0)), "R3", "36 MHz wait states",
        int'(flash_ws), 1);
    chk(last_switch_ws == 1, "R7", "ws raised before switch", last_switch_ws, 1);
  endtask

  task automatic t_pll_ext_park();
    run_ok("R3", 1, 1, 9, 8);
    chk(pll_src_ext, "R3", "external feeds PLL", int'(pll_src_ext), 1);
    chk(saw_int, "R11", "mux parked on internal", int'(saw_int), 1);
    chk(saw_pll_off, "R4", "PLL disabled for reprogram", int'(saw_pll_off), 1);
    chk(last_switch_ws == 2, "R7", "ws 2 before switch", last_switch_ws, 2);
    chk(int'(pll_mul_code) == 7, "R2", "code for x9", int'(pll_mul_code), 7);
  endtask

  task automatic t_reject();
    launch(1, 1, 10, 8);
    wait_end();
    chk(r_rerr && !r_done, "R8", "80 MHz rejected", int'(r_rerr), 1);
    chk(clk_sel == 2'b10 && flash_ws == 2 && pll_mul_code == 7 && pll_src_ext,
        "R8", "outputs unchanged", int'({clk_sel, flash_ws, pll_mul_code}),
        int'({2'b10, 2'd2, 4'd7}));
    repeat (3) @(negedge clk);
    chk(!done, "R8", "no late done", int'(done), 0);
  endtask

  task automatic t_clamp();
    run_ok("R2", 0, 1, 20, 0);
    chk(int'(pll_mul_code) == exp_code(20), "R2", "high clamp", int'(pll_mul_code), 14);
    run_ok("R2", 1, 1, 0, 8);
    chk(int'(pll_mul_code) == exp_code(0), "R2", "low clamp", int'(pll_mul_code), 0);
    chk(last_switch_ws == 2, "R7", "ws lowered after switch", last_switch_ws, 2);
    chk(flash_ws == 0, "R7", "ws finally 0", int'(flash_ws), 0);
    chk(field_viol == 0, "R4", "fields moved while enabled", field_viol, 0);
  endtask

  task automatic t_thresholds();
    int vals[5] = '{24, 25, 48, 49, 72};
    foreach (vals[k]) run_ok("R6", 1, 0, 0, vals[k]);
    launch(1, 0, 0, 73);
    wait_end();
    chk(r_rerr && !r_done, "R8", "73 MHz rejected", int'(r_rerr), 1);
    chk(flash_ws == 2 && clk_sel == 2'b01, "R8", "state kept after reject",
        int'({clk_sel, flash_ws}), int'({2'b01, 2'd2}));
  endtask

  task automatic t_xosc_timeout();
    xosc_dead = 1'b1;
    repeat (XDLY + 2) @(negedge clk);
    launch(1, 0, 0, 8);
    wait_end();
    chk(r_terr && !r_done, "R9", "xosc timeout flagged", int'(r_terr), 1);
    chk(r_cyc >= TMO, "R9", "stalled full window", r_cyc, TMO);
    chk(sel_changes == 0, "R1", "mux held while not ready", sel_changes, 0);
    chk(xosc_en, "R1", "enable kept during wait", int'(xosc_en), 1);
    chk(flash_ws == 2, "R9", "ws unchanged", int'(flash_ws), 2);
    xosc_dead = 1'b0;
    repeat (XDLY + 2) @(negedge clk);
  endtask

  task automatic t_pll_timeout_recover();
    pll_dead = 1'b1;
    repeat (PDLY + 2) @(negedge clk);
    launch(0, 1, 4, 0);
    wait_end();
    chk(r_terr && !r_done, "R4", "no lock, timeout", int'(r_terr), 1);
    chk(clk_sel == 2'b01, "R9", "mux unchanged", int'(clk_sel), 1);
    chk(pll_en && pll_mul_code == 2, "R4", "PLL enabled after fields",
        int'({pll_en, pll_mul_code}), int'({1'b1, 4'd2}));
    pll_dead = 1'b0;
    run_ok("R9", 0, 1, 4, 0);
    chk(!err_timeout, "R10", "error cleared by start", int'(err_timeout), 0);
    chk(field_viol == 0, "R4", "fields frozen while enabled", field_viol, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_internal();
    t_ext_direct();
    t_pll_internal_busy_start();
    t_pll_ext_park();
    t_reject();
    t_clamp();
    t_thresholds();
    t_xosc_timeout();
    t_pll_timeout_recover();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule